// File: doc/BRIEF.md
# In-Order Issue Scoreboard

This block sits at the issue stage of an in-order pipeline with four functional units of different fixed latencies. Each cycle decode presents one instruction: the unit class it needs, an optional destination register, and two source registers. The scoreboard decides in the same cycle whether the instruction dispatches or stalls. Decode holds a stalled instruction and presents it again.

The block keeps one pending-write bit per architectural register and one countdown per functional unit. On dispatch, the chosen unit loads its latency and the destination becomes pending. When the countdown reaches its last cycle, the unit raises a writeback event that carries the destination register. On the following edge the unit becomes free and the pending bit clears. Register 0 is never tracked. Because operands are taken in order at issue, write-after-read needs no check. Write-after-write and read-after-write are both resolved by stalling.

Top module: `issue_scoreboard`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, no unit is busy, no register is pending, `wb_valid` is all zero and `dec_stall` is low.
- R2: Unit codes on `dec_unit` are 0 integer/load, 1 add, 2 multiply, 3 divide, with latencies 1, 1, 3 and 4. For an instruction issued in cycle c on unit u with latency L, bit u of `wb_valid` is high in cycle c+L and only in that cycle.
- R3: Each unit is unpipelined. A request for unit u stalls from the cycle after that unit's issue up to and including its writeback cycle.
- R4: A request stalls when either source register is pending.
- R5: A request with a destination stalls when that destination is pending. An issued instruction with a nonzero destination makes that register pending from the next cycle until its writeback.
- R6: In a unit's writeback cycle, its destination still counts as pending, so a request that uses that register stalls in that cycle and can issue in the next one.
- R7: Register 0 never becomes pending. An instruction with `dec_has_dst` low marks no register pending.
- R8: `dec_issue` equals `dec_valid` and not `dec_stall`. `dec_stall` is low whenever `dec_valid` is low. At most one instruction issues per cycle.
- R9: During a writeback event of unit u, bits [u*RW +: RW] of `wb_dst` hold that instruction's destination, or 0 when it had none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode presents an instruction |
| dec_unit | input | 2 | Functional unit class (0 int/load, 1 add, 2 mul, 3 div) |
| dec_has_dst | input | 1 | Instruction writes a destination register |
| dec_dst | input | RW | Destination register number |
| dec_src_a | input | RW | First source register number |
| dec_src_b | input | RW | Second source register number |
| dec_stall | output | 1 | Instruction must be held |
| dec_issue | output | 1 | Instruction dispatches this cycle |
| wb_valid | output | 4 | Per-unit writeback event |
| wb_dst | output | 4*RW | Per-unit writeback destination, RW bits per unit |

## Verification
The bench goes after the writeback cycle itself. A request that uses the register being written back in that cycle must stall, and a design that cleared the pending bit one cycle early would let it through and read a stale operand. It also targets a unit that writes back and is requested again in the same cycle, where an early release would double-book an unpipelined unit. It aims traffic at register 0 and at instructions with no destination, where a design that tracked them would stall forever or without cause. Long-latency divides overlap short operations on distinct units, so a counter that is off by one shows up as a writeback event in the wrong cycle or carrying the wrong register.

// File: rtl/issue_scoreboard.sv
module issue_scoreboard #(
  parameter int NUM_REGS = 32,
  parameter int LAT_INT  = 1,
  parameter int LAT_ADD  = 1,
  parameter int LAT_MUL  = 3,
  parameter int LAT_DIV  = 4,
  localparam int RW = $clog2(NUM_REGS),
  localparam int NU = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [1:0]       dec_unit,
  input  logic             dec_has_dst,
  input  logic [RW-1:0]    dec_dst,
  input  logic [RW-1:0]    dec_src_a,
  input  logic [RW-1:0]    dec_src_b,
  output logic             dec_stall,
  output logic             dec_issue,
  output logic [NU-1:0]    wb_valid,
  output logic [NU*RW-1:0] wb_dst
);
  localparam int MAXL01 = (LAT_INT > LAT_ADD) ? LAT_INT : LAT_ADD;
  localparam int MAXL23 = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
  localparam int MAXLAT = (MAXL01 > MAXL23) ? MAXL01 : MAXL23;
  localparam int CW = $clog2(MAXLAT + 1);

  logic [NUM_REGS-1:0]     pend;
  logic [NUM_REGS-1:0]     pend_clr, pend_set;
  logic [NU-1:0]           busy;
  logic [NU-1:0][RW-1:0]   udst;
  logic [NU-1:0][CW-1:0]   ucnt;

  wire raw_hit = pend[dec_src_a] | pend[dec_src_b];
  wire waw_hit = dec_has_dst & pend[dec_dst];

  assign dec_stall = dec_valid & (busy[dec_unit] | raw_hit | waw_hit);
  assign dec_issue = dec_valid & ~dec_stall;

  for (genvar u = 0; u < NU; u++) begin : g_unit
    localparam int L = (u == 0) ? LAT_INT : (u == 1) ? LAT_ADD : (u == 2) ? LAT_MUL : LAT_DIV;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ucnt[u] <= '0;
        udst[u] <= '0;
      end else if (dec_issue && dec_unit == 2'(u)) begin
        ucnt[u] <= CW'(L);
        udst[u] <= dec_has_dst ? dec_dst : '0;
      end else if (ucnt[u] != '0) begin
        ucnt[u] <= ucnt[u] - 1'b1;
      end
    end

    assign busy[u]              = ucnt[u] != '0;
    assign wb_valid[u]          = ucnt[u] == CW'(1);
    assign wb_dst[u*RW +: RW]   = udst[u];
  end

  always_comb begin
    pend_clr = '0;
    pend_set = '0;
    for (int u = 0; u < NU; u++)
      if (wb_valid[u]) pend_clr[udst[u]] = 1'b1;
    if (dec_issue && dec_has_dst && dec_dst != '0)
      pend_set[dec_dst] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~pend_clr) | pend_set;
  end
endmodule

// File: rtl/scoreboard_checks.sv
module scoreboard_checks #(
  parameter int NUM_REGS = 32,
  localparam int RW = $clog2(NUM_REGS),
  localparam int NU = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dec_valid,
  input logic                dec_has_dst,
  input logic [RW-1:0]       dec_dst,
  input logic [RW-1:0]       dec_src_a,
  input logic [RW-1:0]       dec_src_b,
  input logic                dec_stall,
  input logic                dec_issue,
  input logic [NU-1:0]       wb_valid,
  input logic [NU*RW-1:0]    wb_dst,
  input logic [NUM_REGS-1:0] pend
);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_stall && !dec_issue));

  assert_raw_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_issue |-> (!pend[dec_src_a] && !pend[dec_src_b]));

  assert_waw_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_issue && dec_has_dst) |-> !pend[dec_dst]);

  assert_dst_marked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_issue && dec_has_dst && dec_dst != '0) |=> pend[$past(dec_dst)]);

  assert_zero_untracked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[0]);

  for (genvar u = 0; u < NU; u++) begin : g_chk
    wire [RW-1:0] d = wb_dst[u*RW +: RW];

    assert_wb_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid[u] |=> !wb_valid[u]);

    assert_wb_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid[u] && d != '0 && dec_valid &&
       (dec_src_a == d || dec_src_b == d || (dec_has_dst && dec_dst == d))) |-> dec_stall);
  end
endmodule

bind issue_scoreboard scoreboard_checks #(.NUM_REGS(NUM_REGS)) chk (.*);

// File: tb/issue_scoreboard_test.sv
module issue_scoreboard_test;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 32;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0, dec_has_dst = 1'b0;
  logic [1:0] dec_unit = '0;
  logic [RW-1:0] dec_dst = '0, dec_src_a = '0, dec_src_b = '0;
  logic dec_stall, dec_issue;
  logic [3:0] wb_valid;
  logic [4*RW-1:0] wb_dst;

  always #(CLK_PERIOD/2) clk = ~clk;

  issue_scoreboard uut (.*);

  int total = 0, bad = 0;
  int pend_m[NR];
  int cnt_m[4];
  int dst_m[4];
  int lat_m[4] = '{1, 1, 3, 4};

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(bit v, int u, bit hd, int d, int a, int b, output bit iss);
    bit busy, raw, waw, coll, st_e;
    string req;
    @(negedge clk);
    dec_valid = v; dec_unit = 2'(u); dec_has_dst = hd;
    dec_dst = RW'(d); dec_src_a = RW'(a); dec_src_b = RW'(b);
    #1;
    busy = cnt_m[u] > 0;
    raw  = pend_m[a] != 0 || pend_m[b] != 0;
    waw  = hd && pend_m[d] != 0;
    st_e = v && (busy || raw || waw);
    coll = 1'b0;
    for (int k = 0; k < 4; k++)
      if (cnt_m[k] == 1 && dst_m[k] != 0 && (dst_m[k] == a || dst_m[k] == b || (hd && dst_m[k] == d)))
        coll = 1'b1;
    req = busy ? "R3" : coll ? "R6" : raw ? "R4" : waw ? "R5" :
          (a == 0 || b == 0 || d == 0 || !hd) ? "R7" : "R8";
    chk(dec_stall == st_e, req, "stall", dec_stall, st_e);
    chk(dec_issue == (v && !st_e), "R8", "issue", dec_issue, v && !st_e);
    for (int k = 0; k < 4; k++) begin
      chk(wb_valid[k] == (cnt_m[k] == 1), "R2", "wb_valid", wb_valid[k], cnt_m[k] == 1);
      if (cnt_m[k] == 1)
        chk(wb_dst[k*RW +: RW] == RW'(dst_m[k]), "R9", "wb_dst", wb_dst[k*RW +: RW], dst_m[k]);
    end
    for (int k = 0; k < 4; k++) begin
      if (cnt_m[k] == 1) pend_m[dst_m[k]] = 0;
      if (cnt_m[k] > 0) cnt_m[k]--;
    end
    iss = v && !st_e;
    if (iss) begin
      cnt_m[u] = lat_m[u];
      dst_m[u] = hd ? d : 0;
      if (hd && d != 0) pend_m[d] = 1;
    end
  endtask

  task automatic send(int u, bit hd, int d, int a, int b);
    bit iss = 1'b0;
    for (int n = 0; n < 20 && !iss; n++) step(1'b1, u, hd, d, a, b, iss);
    chk(iss, "R8", "eventually_issued", iss, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit iss;
    for (int i = 0; i < NR; i++) pend_m[i] = 0;
    for (int k = 0; k < 4; k++) begin cnt_m[k] = 0; dst_m[k] = 0; end

    repeat (2) @(negedge clk);
    dec_valid = 1'b1; dec_unit = 2'd3; dec_has_dst = 1'b1; dec_dst = 5'd6;
    #1;
    chk(dec_stall == 1'b0, "R1", "stall_in_reset", dec_stall, 0);
    chk(wb_valid == 4'b0, "R1", "wb_in_reset", wb_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    dec_valid = 1'b0;
    #1;
    chk(wb_valid == 4'b0, "R1", "wb_after_reset", wb_valid, 0);

    // divide then load, multiply waits for load result (R4), divide reuses busy unit (R3)
    send(3, 1, 6, 6, 4);
    send(0, 1, 2, 3, 0);
    send(2, 1, 1, 2, 4);
    send(3, 1, 8, 6, 2);
    send(1, 1, 10, 1, 6);
    send(1, 1, 6, 8, 2);
    repeat (6) step(1'b0, 0, 0, 0, 0, 0, iss);

    // WAW across units (R5)
    send(2, 1, 5, 0, 0);
    send(0, 1, 5, 0, 0);
    repeat (5) step(1'b0, 0, 0, 0, 0, 0, iss);

    // same-cycle writeback still blocks (R6)
    send(2, 1, 3, 0, 0);
    step(1'b0, 0, 0, 0, 0, 0, iss);
    step(1'b0, 0, 0, 0, 0, 0, iss);
    step(1'b1, 1, 1, 9, 3, 0, iss);
    chk(iss == 1'b0, "R6", "stall_in_wb_cycle", iss, 0);
    step(1'b1, 1, 1, 9, 3, 0, iss);
    chk(iss == 1'b1, "R6", "issue_after_wb", iss, 1);
    repeat (3) step(1'b0, 0, 0, 0, 0, 0, iss);

    // register 0 and no-destination never tracked (R7)
    send(3, 1, 0, 0, 0);
    send(2, 0, 7, 0, 0);
    step(1'b1, 1, 1, 0, 0, 0, iss);
    chk(iss == 1'b1, "R7", "r0_not_pending", iss, 1);
    step(1'b1, 0, 1, 4, 7, 7, iss);
    chk(iss == 1'b1, "R7", "nodst_not_pending", iss, 1);
    repeat (6) step(1'b0, 0, 0, 0, 0, 0, iss);

    // mixed traffic on a small register window
    for (int n = 0; n < 1500; n++)
      step(($urandom % 4) != 0, int'($urandom % 4), ($urandom % 5) != 0,
           int'($urandom % 8), int'($urandom % 8), int'($urandom % 8), iss);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule